// File: doc/BRIEF.md
# Two-Stage CAN Receive Frame Holder

This block keeps completed CAN frames in two stages so the host has time to read one frame while the next one arrives. A staging buffer takes every frame the bus logic reports as complete. A host buffer is the only one software reads. A full flag guards the host buffer, and the host gives it back by pulsing a release input. Each frame is a record of thirteen bytes that the bus logic hands over in parallel with a completion strobe.

A staged frame is handed to the host buffer only when it passed the identifier filter and the host buffer is free. Frames that this node sent itself are held back from the host, unless the loopback mode is on. In loopback mode they are treated like frames from any other node. When both stages hold frames that wait for the host, further frames are dropped. If a dropped frame was one the host should have seen, a sticky overrun flag is set. The receive and error interrupt lines are the two flags, each gated by its own enable input.

Top module: `dual_rx_buffer`

## Requirements
- R1: After a synchronous reset, the full flag, the overrun flag and both interrupt lines are 0, and every byte of both buffers reads 0.
- R2: A completed frame is written into the staging buffer at the next clock edge, whether or not its identifier was accepted, and it replaces the previous contents. The only exception is the case in R8.
- R3: A staged frame that was accepted and is eligible is copied into the host buffer one cycle after it was staged, if the full flag is clear. The full flag rises in that same cycle.
- R4: While the full flag is set, the host buffer does not change and no frame is handed over. A release pulse clears the full flag at the next edge. A frame that was waiting is handed over one cycle after that.
- R5: With loopback off, a self-sent frame is written into the staging buffer but never reaches the host buffer. It does not set the full flag or the receive interrupt.
- R6: With loopback on, an accepted self-sent frame is handed to the host exactly like a frame from another node.
- R7: When the full flag is set and a waiting frame is staged, an accepted and eligible completed frame is discarded, the staging buffer keeps its contents, and the overrun flag is set at the next edge.
- R8: While both stages are occupied, every completed frame is discarded, including rejected frames and self-sent frames. Such frames do not set the overrun flag.
- R9: The overrun flag stays set until the overrun clear input is pulsed. If an overrun and a clear arrive in the same cycle, the flag stays set.
- R10: The receive interrupt equals the full flag AND the receive enable. The error interrupt equals the overrun flag AND the error enable. Both follow their flag in the same cycle.
- R11: A completed frame whose identifier was rejected is staged but never handed to the host.
- R12: A frame that completes in the same cycle as a hand-over goes into the staging buffer and waits there. A release pulse while the full flag is clear has no effect.
- R13: The read port returns byte rd_idx of the host buffer when rd_from_bg is 0, and of the staging buffer when it is 1. Byte 0 is frm_data[7:0]. An index of 13 or more reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_done | input | 1 | One-cycle strobe: a frame completed on the bus |
| frm_accept | input | 1 | The completed frame passed the identifier filter |
| frm_self | input | 1 | The completed frame was sent by this node |
| frm_data | input | 104 | Frame record, byte k in bits [8k+7:8k] |
| loopback | input | 1 | Treat self-sent frames like frames from other nodes |
| rx_ie | input | 1 | Receive interrupt enable |
| err_ie | input | 1 | Overrun interrupt enable |
| host_release | input | 1 | Pulse: host gives back the host buffer |
| ovr_wclr | input | 1 | Pulse: clear the overrun flag |
| rd_from_bg | input | 1 | Read select: 0 host buffer, 1 staging buffer |
| rd_idx | input | 4 | Byte index for the read port |
| rd_byte | output | 8 | Selected byte |
| rxf | output | 1 | Host buffer full flag |
| ovr | output | 1 | Sticky overrun flag |
| rx_irq | output | 1 | Receive interrupt |
| err_irq | output | 1 | Overrun interrupt |

## Verification
Suppose the internal "frame waiting" bit is wrong. A hand-over that should happen shows up as rxf failing to rise, and the host buffer holding stale bytes one cycle after the frame completes. A hand-over that should not happen shows up as rxf rising, or the host bytes changing, where no frame was eligible. A wrong occupancy decision shows up one edge later. Either the staging bytes change while both stages are full, or ovr fails to be set or is set without cause. Every error therefore becomes visible on rxf, ovr or the read port within two cycles of the completion strobe or the release pulse that triggered it.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int unsigned REC_BYTES_DEF = 13;
    localparam int unsigned BYTE_W_DEF    = 8;

    // Event reported by the bus logic when a frame completes
    typedef struct packed {
        logic done;
        logic accepted;
        logic self_tx;
    } frm_evt_t;

    // Occupancy of the two stages: {host full, staging waiting}
    typedef enum logic [1:0] {
        OCC_NONE = 2'b00,
        OCC_BG   = 2'b01,
        OCC_FG   = 2'b10,
        OCC_BOTH = 2'b11
    } occ_t;

    // A frame may go to the host when it passed the filter and is not a hidden self-sent frame
    function automatic logic rx_eligible(frm_evt_t e, logic lb);
        return e.accepted && (!e.self_tx || lb);
    endfunction

    function automatic int unsigned idx_width(int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/rxq_stage_ctrl.sv
module rxq_stage_ctrl
    import rxq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  frm_evt_t evt,
    input  logic     loopback,
    input  logic     host_release,
    input  logic     ovr_wclr,
    output logic     load_bg,
    output logic     load_fg,
    output logic     bg_pend,
    output logic     rxf,
    output logic     ovr
);

    occ_t occ;
    logic promote;
    logic both_full;
    logic elig;
    logic ovr_set;

    always_comb begin
        occ       = occ_t'({rxf, bg_pend});
        promote   = (occ == OCC_BG);
        both_full = (occ == OCC_BOTH);
        elig      = rx_eligible(evt, loopback);
        load_fg   = promote;
        load_bg   = evt.done && !both_full;
        ovr_set   = evt.done && both_full && elig;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rxf     <= 1'b0;
            bg_pend <= 1'b0;
            ovr     <= 1'b0;
        end else begin
            if (promote)
                rxf <= 1'b1;
            else if (host_release)
                rxf <= 1'b0;

            if (load_bg)
                bg_pend <= elig;
            else if (promote)
                bg_pend <= 1'b0;

            if (ovr_set)
                ovr <= 1'b1;
            else if (ovr_wclr)
                ovr <= 1'b0;
        end
    end

endmodule

// File: rtl/rxq_record_store.sv
module rxq_record_store #(
    parameter int unsigned N = 13,
    parameter int unsigned W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [N-1:0][W-1:0] din,
    output logic [N-1:0][W-1:0] dout
);

    for (genvar g = 0; g < N; g++) begin : g_cell
        logic [W-1:0] cell_q;

        always_ff @(posedge clk) begin
            if (rst)
                cell_q <= '0;
            else if (load)
                cell_q <= din[g];
        end

        assign dout[g] = cell_q;
    end

endmodule

// File: rtl/rxq_read_mux.sv
module rxq_read_mux #(
    parameter int unsigned N  = 13,
    parameter int unsigned W  = 8,
    parameter int unsigned IW = 4
) (
    input  logic [N-1:0][W-1:0] fg,
    input  logic [N-1:0][W-1:0] bg,
    input  logic                from_bg,
    input  logic [IW-1:0]       idx,
    output logic [W-1:0]        byte_o
);

    logic [N-1:0][W-1:0] sel;

    always_comb begin
        sel    = from_bg ? bg : fg;
        byte_o = '0;
        for (int i = 0; i < N; i++) begin
            if (32'(idx) == i)
                byte_o = sel[i];
        end
    end

endmodule

// File: rtl/dual_rx_buffer.sv
module dual_rx_buffer
    import rxq_pkg::*;
#(
    parameter  int unsigned REC_BYTES = REC_BYTES_DEF,
    parameter  int unsigned BYTE_W    = BYTE_W_DEF,
    localparam int unsigned IDX_W     = idx_width(REC_BYTES),
    localparam int unsigned REC_W     = REC_BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frm_done,
    input  logic              frm_accept,
    input  logic              frm_self,
    input  logic [REC_W-1:0]  frm_data,
    input  logic              loopback,
    input  logic              rx_ie,
    input  logic              err_ie,
    input  logic              host_release,
    input  logic              ovr_wclr,
    input  logic              rd_from_bg,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              rxf,
    output logic              ovr,
    output logic              rx_irq,
    output logic              err_irq
);

    frm_evt_t                            evt;
    logic                                load_bg;
    logic                                load_fg;
    logic                                bg_pend;
    logic [REC_BYTES-1:0][BYTE_W-1:0]    din_arr;
    logic [REC_BYTES-1:0][BYTE_W-1:0]    bg_q;
    logic [REC_BYTES-1:0][BYTE_W-1:0]    fg_q;

    assign evt     = '{done: frm_done, accepted: frm_accept, self_tx: frm_self};
    assign din_arr = frm_data;

    rxq_stage_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .evt          (evt),
        .loopback     (loopback),
        .host_release (host_release),
        .ovr_wclr     (ovr_wclr),
        .load_bg      (load_bg),
        .load_fg      (load_fg),
        .bg_pend      (bg_pend),
        .rxf          (rxf),
        .ovr          (ovr)
    );

    rxq_record_store #(.N(REC_BYTES), .W(BYTE_W)) u_bg (
        .clk  (clk),
        .rst  (rst),
        .load (load_bg),
        .din  (din_arr),
        .dout (bg_q)
    );

    rxq_record_store #(.N(REC_BYTES), .W(BYTE_W)) u_fg (
        .clk  (clk),
        .rst  (rst),
        .load (load_fg),
        .din  (bg_q),
        .dout (fg_q)
    );

    rxq_read_mux #(.N(REC_BYTES), .W(BYTE_W), .IW(IDX_W)) u_rd (
        .fg      (fg_q),
        .bg      (bg_q),
        .from_bg (rd_from_bg),
        .idx     (rd_idx),
        .byte_o  (rd_byte)
    );

    assign rx_irq  = rxf && rx_ie;
    assign err_irq = ovr && err_ie;

endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
    parameter int unsigned N = 13,
    parameter int unsigned W = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                frm_done,
    input logic                frm_accept,
    input logic                frm_self,
    input logic                loopback,
    input logic                ovr_wclr,
    input logic                rxf,
    input logic                ovr,
    input logic                bg_pend,
    input logic [N-1:0][W-1:0] bg_q,
    input logic [N-1:0][W-1:0] fg_q
);

    AST_PROMOTE_NEXT: assert property (@(posedge clk) disable iff (rst)
        bg_pend && !rxf |=> rxf && (fg_q == $past(bg_q))); // R3

    AST_FG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        rxf |=> $stable(fg_q)); // R4

    AST_OWN_HIDDEN: assert property (@(posedge clk) disable iff (rst)
        frm_done && frm_self && !loopback && !(rxf && bg_pend) |=> !bg_pend); // R5

    AST_LOOPBACK_WAIT: assert property (@(posedge clk) disable iff (rst)
        frm_done && frm_accept && loopback && !(rxf && bg_pend) |=> bg_pend); // R6

    AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr) |-> $past(frm_done && frm_accept && rxf && bg_pend)); // R7

    AST_FULL_DISCARD: assert property (@(posedge clk) disable iff (rst)
        frm_done && rxf && bg_pend |=> $stable(bg_q) && bg_pend); // R8

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovr && !ovr_wclr |=> ovr); // R9

endmodule

bind dual_rx_buffer rxq_checker #(.N(REC_BYTES), .W(BYTE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .frm_done   (frm_done),
    .frm_accept (frm_accept),
    .frm_self   (frm_self),
    .loopback   (loopback),
    .ovr_wclr   (ovr_wclr),
    .rxf        (rxf),
    .ovr        (ovr),
    .bg_pend    (bg_pend),
    .bg_q       (bg_q),
    .fg_q       (fg_q)
);

// File: tb/dual_rx_buffer_bench.sv
`timescale 1ns/1ps
module dual_rx_buffer_bench;
    import rxq_pkg::*;

    localparam int unsigned NB = REC_BYTES_DEF;
    localparam int unsigned BW = BYTE_W_DEF;
    localparam int unsigned IW = idx_width(NB);

    typedef logic [NB-1:0][BW-1:0] rec_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          frm_done = 0, frm_accept = 0, frm_self = 0;
    rec_t          frm_data = '0;
    logic          loopback = 0, rx_ie = 1, err_ie = 1;
    logic          host_release = 0, ovr_wclr = 0, rd_from_bg = 0;
    logic [IW-1:0] rd_idx = '0;
    logic [BW-1:0] rd_byte;
    logic          rxf, ovr, rx_irq, err_irq;

    dual_rx_buffer u_dual_rx_buffer (
        .clk (clk), .rst (rst),
        .frm_done (frm_done), .frm_accept (frm_accept), .frm_self (frm_self),
        .frm_data (frm_data), .loopback (loopback), .rx_ie (rx_ie), .err_ie (err_ie),
        .host_release (host_release), .ovr_wclr (ovr_wclr),
        .rd_from_bg (rd_from_bg), .rd_idx (rd_idx), .rd_byte (rd_byte),
        .rxf (rxf), .ovr (ovr), .rx_irq (rx_irq), .err_irq (err_irq)
    );

    always #2.5 clk = ~clk;

    int   total = 0;
    int   bad   = 0;
    rec_t m_bg, m_fg;
    logic m_pend, m_rxf, m_ovr;

    function automatic rec_t mk(int s);
        rec_t r;
        for (int i = 0; i < NB; i++) r[i] = BW'(s * 17 + i * 5 + 1);
        return r;
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        chk(tag, "rxf", 32'(rxf), 32'(m_rxf));
        chk(tag, "ovr", 32'(ovr), 32'(m_ovr));
        chk({tag, "/R10"}, "rx_irq", 32'(rx_irq), 32'(m_rxf && rx_ie));
        chk({tag, "/R10"}, "err_irq", 32'(err_irq), 32'(m_ovr && err_ie));
        for (int i = 0; i < NB; i++) begin
            rd_idx = IW'(i);
            rd_from_bg = 1'b0; #0.04;
            chk(tag, "host byte", 32'(rd_byte), 32'(m_fg[i]));
            rd_from_bg = 1'b1; #0.04;
            chk(tag, "staging byte", 32'(rd_byte), 32'(m_bg[i]));
        end
        rd_idx = IW'(NB); rd_from_bg = 1'b0; #0.04;
        chk("R13", "out of range byte", 32'(rd_byte), 32'h0);
    endtask

    // Expected next state, derived from R2..R12
    task automatic step(bit fd, bit acc, bit own, bit rel, bit oclr, rec_t data, string tag);
        logic full, prom, elig;
        frm_done = fd; frm_accept = acc; frm_self = own;
        host_release = rel; ovr_wclr = oclr; frm_data = data;
        @(posedge clk);
        full = m_rxf && m_pend;
        prom = m_pend && !m_rxf;
        elig = acc && (!own || loopback);
        if (prom) m_fg = m_bg;
        if (fd && !full) begin
            m_bg = data; m_pend = elig;
        end else if (prom) m_pend = 1'b0;
        if (prom) m_rxf = 1'b1;
        else if (rel) m_rxf = 1'b0;
        if (fd && full && elig) m_ovr = 1'b1;
        else if (oclr) m_ovr = 1'b0;
        @(negedge clk);
        frm_done = 0; host_release = 0; ovr_wclr = 0;
        compare_all(tag);
    endtask

    task automatic idle(string tag);
        step(0, 0, 0, 0, 0, '0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'h5EED_0042);
        m_bg = '0; m_fg = '0; m_pend = 0; m_rxf = 0; m_ovr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        compare_all("R1");

        // R2/R3: accepted foreign frame, staged then handed over
        step(1, 1, 0, 0, 0, mk(1), "R2");
        chk("R3", "rxf before hand-over", 32'(rxf), 0);
        idle("R3");
        chk("R3", "rxf after hand-over", 32'(rxf), 1);

        // R4: waiting frame held while full, handed over after release
        step(1, 1, 0, 0, 0, mk(2), "R4");
        idle("R4"); idle("R4");
        step(0, 0, 0, 1, 0, '0, "R4");
        chk("R4", "rxf cleared", 32'(rxf), 0);
        idle("R4");

        // R5: self-sent frame, loopback off
        step(0, 0, 0, 1, 0, '0, "R5");
        step(1, 1, 1, 0, 0, mk(3), "R5");
        idle("R5");
        chk("R5", "self frame no rxf", 32'(rxf), 0);

        // R11: rejected frame staged, not handed over
        step(1, 0, 0, 0, 0, mk(4), "R11");
        idle("R11");
        chk("R11", "rejected no rxf", 32'(rxf), 0);

        // R6: loopback self frame handed over
        loopback = 1;
        step(1, 1, 1, 0, 0, mk(5), "R6");
        idle("R6");
        chk("R6", "loopback rxf", 32'(rxf), 1);
        loopback = 0;

        // R7/R8: fill both stages, then overrun and discards
        step(1, 1, 0, 0, 0, mk(6), "R7");
        step(1, 1, 0, 0, 0, mk(7), "R7");
        chk("R7", "ovr set", 32'(ovr), 1);
        step(1, 0, 0, 0, 0, mk(8), "R8");
        step(1, 1, 1, 0, 0, mk(9), "R8");

        // R9: sticky, clear, and set winning over clear
        idle("R9");
        step(0, 0, 0, 0, 1, '0, "R9");
        chk("R9", "ovr cleared", 32'(ovr), 0);
        step(1, 1, 0, 0, 1, mk(10), "R9");
        chk("R9", "set wins", 32'(ovr), 1);
        err_ie = 0; idle("R10"); err_ie = 1;
        step(0, 0, 0, 0, 1, '0, "R9");

        // R12: frame during hand-over cycle, then release while empty
        step(0, 0, 0, 1, 0, '0, "R12");
        step(1, 1, 0, 0, 0, mk(11), "R12");
        idle("R12");
        step(0, 0, 0, 1, 0, '0, "R12");
        idle("R12");
        step(0, 0, 0, 1, 0, '0, "R12");
        step(0, 0, 0, 1, 0, '0, "R12");
        idle("R12");

        // Random traffic
        for (int n = 0; n < 1500; n++) begin
            rec_t d;
            bit fd, acc, own, rel, oclr;
            for (int i = 0; i < NB; i++) d[i] = BW'($urandom);
            fd   = ($urandom % 2) == 0;
            acc  = ($urandom % 4) != 0;
            own  = ($urandom % 4) == 0;
            rel  = ($urandom % 6) == 0;
            oclr = ($urandom % 8) == 0;
            if (($urandom % 32) == 0) loopback = ~loopback;
            if (($urandom % 16) == 0) rx_ie = ~rx_ie;
            if (($urandom % 16) == 0) err_ie = ~err_ie;
            step(fd, acc, own, rel, oclr, d, "R3/R7");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule